// File: doc/BRIEF.md
# Sampling Converter Conversion and Readout Controller

This block is the digital control section of a 16-bit sampling converter. A host drives three active-low strobes: conversion start, chip select and read. The block answers with a BUSY status and a 16-bit result bus. A fixed-length cycle counter stands in for the successive-approximation core. The digitized value arrives on a test input and is captured when a conversion is accepted. All host strobes pass through two-stage synchronizers before any edge is detected.

The result register keeps the last completed conversion until the next one finishes. Because of this, the block works in several ways. With chip select and read tied low, the bus stays driven and the new value is valid when BUSY rises. With read and start tied together, a single strobe starts a conversion and reads the previous result. With read strobed on its own, the bus can be shared. The three-state pad sits outside the block: `bus_oe` is its enable, and `bus_q` is zero whenever that enable is low.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A conversion is accepted when a falling edge of `conv_n` is detected while the synchronized `sel_n` is low. BUSY falls at the third rising clock edge after the falling edge of `conv_n` is set up.
- R2: A falling edge of `conv_n` while `sel_n` is high starts nothing, and BUSY stays high.
- R3: While a conversion runs, further falling edges of `conv_n` are ignored, including one detected in the cycle the conversion completes. They do not restart the timer or recapture the sample.
- R4: BUSY is low for exactly CONV_CYCLES clock cycles per accepted conversion.
- R5: The result register changes only at the clock edge where BUSY returns high. Until that edge it holds the previous result.
- R6: `sample_in` is captured at the accepting edge. Later changes during the conversion do not affect the result.
- R7: `bus_oe` is high only when both `sel_n` and `rd_n` are low, after a latency of three clock edges. While it is low, `bus_q` reads zero. While it is high, `bus_q` shows the result register.
- R8: After reset, BUSY is high, the result is zero and `bus_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_n | input | 1 | Conversion start strobe, active low, falling edge |
| sel_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| sample_in | input | 16 | Digitized value standing in for the analog core |
| busy | output | 1 | Low while a conversion runs |
| bus_q | output | 16 | Result bus value, zero when not enabled |
| bus_oe | output | 1 | Enable for the external three-state driver |

## Verification
Two events can fall in the same cycle: a conversion completing, and a new start edge being detected. The bench places a second falling edge of `conv_n` so that it reaches edge detection exactly at the completion edge. It then judges that BUSY stays high afterwards and that the result is the first sample. A second overlap is the combined read-start mode. There, the bus enable and the conversion start rise on the same edge, and the bench checks that the bus shows the old result at that moment.

// File: rtl/conv_pkg.sv
package conv_pkg;

    localparam int DATA_W_DEF = 16;
    localparam int CONV_CYCLES_DEF = 80;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } conv_st_e;

    typedef struct packed {
        logic conv_n;
        logic sel_n;
        logic rd_n;
    } host_ctl_t;

    function automatic logic read_selected(host_ctl_t c);
        return (!c.sel_n) && (!c.rd_n);
    endfunction

    function automatic logic start_fall(host_ctl_t now, host_ctl_t prev);
        return prev.conv_n && !now.conv_n;
    endfunction

endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[i] <= 1'b1;
                sync_q[i] <= 1'b1;
            end else begin
                meta_q[i] <= d_in[i];
                sync_q[i] <= meta_q[i];
            end
        end
    end

    assign q_out = sync_q;
endmodule

// File: rtl/conv_timer.sv
module conv_timer
    import conv_pkg::*;
#(
    parameter int DATA_W      = DATA_W_DEF,
    parameter int CONV_CYCLES = CONV_CYCLES_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [DATA_W-1:0] sample,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] cap
);
    localparam int CNT_W = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CONV_CYCLES - 1);

    conv_st_e         st_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            cap   <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (go) begin
                        st_q  <= ST_CONV;
                        cnt_q <= LOAD;
                        cap   <= sample;
                    end
                end
                ST_CONV: begin
                    if (cnt_q == '0) begin
                        st_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (st_q == ST_IDLE);
    assign done = (st_q == ST_CONV) && (cnt_q == '0);

    // R4: the countdown never exceeds its load value
    a_r4_cnt_range: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_CONV) |-> (int'(cnt_q) < CONV_CYCLES));

    // R3, R6: a start during a conversion leaves the captured sample alone
    a_r3_no_recapture: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_CONV && go) |=> $stable(cap));

    // R3: a running conversion does not return to idle before its count ends
    a_r3_no_early_end: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_CONV && cnt_q != '0) |=> (st_q == ST_CONV));
endmodule

// File: rtl/out_stage.sv
module out_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic [DATA_W-1:0] cap,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] bus_q,
    output logic              bus_oe
);
    logic [DATA_W-1:0] result_q;
    logic              oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            oe_q     <= 1'b0;
        end else begin
            if (done) result_q <= cap;
            oe_q <= rd_sel;
        end
    end

    assign bus_oe = oe_q;
    assign bus_q  = oe_q ? result_q : '0;

    // R5: result register holds unless a conversion completes
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(result_q));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import conv_pkg::*;
#(
    parameter int DATA_W      = DATA_W_DEF,
    parameter int CONV_CYCLES = CONV_CYCLES_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_n,
    input  logic              sel_n,
    input  logic              rd_n,
    input  logic [DATA_W-1:0] sample_in,
    output logic              busy,
    output logic [DATA_W-1:0] bus_q,
    output logic              bus_oe
);
    host_ctl_t raw_ctl, sync_ctl, prev_ctl;
    logic      go, done;
    logic [DATA_W-1:0] cap;

    assign raw_ctl = '{conv_n: conv_n, sel_n: sel_n, rd_n: rd_n};

    ctl_sync #(.W($bits(host_ctl_t))) u_sync (
        .clk  (clk),
        .rst  (rst),
        .d_in (raw_ctl),
        .q_out(sync_ctl)
    );

    always_ff @(posedge clk) begin
        if (rst) prev_ctl <= '1;
        else     prev_ctl <= sync_ctl;
    end

    assign go = start_fall(sync_ctl, prev_ctl) && !sync_ctl.sel_n;

    conv_timer #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .go    (go),
        .sample(sample_in),
        .busy  (busy),
        .done  (done),
        .cap   (cap)
    );

    out_stage #(.DATA_W(DATA_W)) u_out (
        .clk   (clk),
        .rst   (rst),
        .done  (done),
        .cap   (cap),
        .rd_sel(read_selected(sync_ctl)),
        .bus_q (bus_q),
        .bus_oe(bus_oe)
    );

    // R1: BUSY only falls when start was low and select low two edges earlier
    a_r1_qualified: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (!$past(conv_n, 2) && !$past(sel_n, 2)));

    // R7: enable only rises when select and read were both low
    a_r7_enable_src: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_oe) |-> (!$past(sel_n, 2) && !$past(rd_n, 2)));

    // R7: a disabled bus reads zero
    a_r7_quiet_bus: assert property (@(posedge clk) disable iff (rst)
        !bus_oe |-> (bus_q == '0));
endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
    localparam int DW = 16;
    localparam int N  = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          conv_n = 1'b1, sel_n = 1'b1, rd_n = 1'b1;
    logic [DW-1:0] sample_in = '0;
    logic          busy, bus_oe;
    logic [DW-1:0] bus_q;

    int errors = 0;
    int checks = 0;
    logic [DW-1:0] exp_q[$];
    logic [DW-1:0] last_res = '0;

    always #5 clk = ~clk;

    adc_seq_ctrl #(.DATA_W(DW), .CONV_CYCLES(N)) uut (
        .clk(clk), .rst(rst), .conv_n(conv_n), .sel_n(sel_n), .rd_n(rd_n),
        .sample_in(sample_in), .busy(busy), .bus_q(bus_q), .bus_oe(bus_oe)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: BUSY low length and result at BUSY rise (R4, R5)
    int  low_cnt = 0;
    logic busy_prev = 1'b1;
    always @(negedge clk) begin
        if (!rst) begin
            if (!busy) low_cnt++;
            if (busy && !busy_prev) begin
                check(low_cnt == N, "R4 busy low length", low_cnt, N);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected completion", 1, 0);
                end else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    check(bus_oe == 1'b1, "R5 bus driven at completion", bus_oe, 1);
                    check(bus_q == e, "R5/R6 result at busy rise", bus_q, e);
                    last_res = e;
                end
                low_cnt = 0;
            end
            busy_prev = busy;
        end
    end

    // driver: start an accepted conversion and check its latency (R1)
    task automatic conv_start(input logic [DW-1:0] s, input logic tie_rd);
        sample_in = s;
        exp_q.push_back(s);
        conv_n = 1'b0;
        if (tie_rd) rd_n = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check(busy == 1'b1, "R1 busy before third edge", busy, 1);
        @(posedge clk);
        @(negedge clk);
        check(busy == 1'b0, "R1 busy falls at third edge", busy, 0);
    endtask

    task automatic wait_idle();
        while (!busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        check(busy == 1'b1, "R8 busy after reset", busy, 1);
        check(bus_oe == 1'b0, "R8 bus disabled after reset", bus_oe, 0);
        check(bus_q == '0, "R8 bus zero after reset", bus_q, 0);

        // R2: start while deselected
        conv_n = 1'b0;
        repeat (3) @(negedge clk);
        conv_n = 1'b1;
        begin
            int seen = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (!busy) seen++;
            end
            check(seen == 0, "R2 no conversion when deselected", seen, 0);
        end

        // always-enabled mode
        sel_n = 1'b0; rd_n = 1'b0;
        repeat (4) @(negedge clk);
        check(bus_oe == 1'b1, "R7 enabled with select and read low", bus_oe, 1);
        check(bus_q == 16'h0000, "R7 shows reset result", bus_q, 0);

        conv_start(16'hA5C3, 1'b0);
        conv_n = 1'b1;
        repeat (3) @(negedge clk);
        sample_in = 16'h1111;                    // R6 change after capture
        @(negedge clk);
        conv_n = 1'b0;                           // R3 edge mid-conversion
        @(negedge clk);
        conv_n = 1'b1;
        wait_idle();
        check(bus_q == 16'hA5C3, "R6 captured value kept", bus_q, 16'hA5C3);

        // R3: edge detected exactly at completion edge
        sample_in = 16'h3C5A;
        exp_q.push_back(16'h3C5A);
        conv_n = 1'b0;                           // before edge k0
        @(posedge clk); @(posedge clk); @(posedge clk);
        @(negedge clk);
        conv_n = 1'b1;
        for (int i = 0; i < N - 3; i++) @(posedge clk);  // through edge k0+N-1
        @(negedge clk);
        sample_in = 16'h7777;
        conv_n = 1'b0;                           // detected at edge k0+N+2 = completion
        begin
            int seen = 0;
            wait_idle();
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                if (!busy) seen++;
            end
            check(seen == 0, "R3 edge at completion ignored", seen, 0);
            check(bus_q == 16'h3C5A, "R3 result from first sample", bus_q, 16'h3C5A);
        end
        conv_n = 1'b1;
        repeat (3) @(negedge clk);

        // R7 enable combinations
        rd_n = 1'b1;
        repeat (4) @(negedge clk);
        check(bus_oe == 1'b0, "R7 read high disables", bus_oe, 0);
        check(bus_q == '0, "R7 bus zero when disabled", bus_q, 0);
        sel_n = 1'b1; rd_n = 1'b0;
        repeat (4) @(negedge clk);
        check(bus_oe == 1'b0, "R7 select high disables", bus_oe, 0);
        sel_n = 1'b0; rd_n = 1'b1;
        repeat (4) @(negedge clk);

        // combined read-start mode: old result during conversion (R5)
        conv_start(16'h0F0F, 1'b1);
        check(bus_oe == 1'b1, "R7 enabled with combined strobe", bus_oe, 1);
        check(bus_q == last_res, "R5 previous result during conversion", bus_q, last_res);
        repeat (N / 2) @(negedge clk);
        check(bus_q == last_res, "R5 previous result mid-conversion", bus_q, last_res);
        wait_idle();
        conv_n = 1'b1; rd_n = 1'b1;
        repeat (4) @(negedge clk);
        check(bus_oe == 1'b0, "R7 released after combined read", bus_oe, 0);

        check(exp_q.size() == 0, "R5 all conversions completed", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule